// File: doc/BRIEF.md
# Programmable Interrupt Routing Matrix

This block steers a small set of interrupt sources onto the system's interrupt request lines. Three general-purpose external pins each get their own 4-bit line number. A fourth source comes from a watchdog and can also carry a chassis-intrusion event. It has a 3-bit selector that reaches either three legacy lines or four advanced-controller lines, numbered 20 to 23. One 16-bit configuration register, written and read through a plain 16-bit port, holds the whole routing.

Pins and status inputs are asynchronous, so they pass through a synchroniser. The outputs are combinational functions of the registered configuration and the synchronised inputs. A pin counts only while its function-enable input selects the interrupt role. Four legacy line numbers are reserved, and nothing ever drives them. The watchdog route stands down while system-control-interrupt routing is active.

Top module: `irq_route_matrix`

## Requirements
- R1: After reset the configuration reads 0000h and every legacy and advanced output is low.
- R2: A write with `cfg_we` high is captured at the next rising clock edge, and `cfg_rdata` returns all 16 written bits. Without a write, the register holds its value.
- R3: External pin n (n = 0, 1, 2) uses configuration bits [4n+3:4n] as a line number L. While the pin is high and enabled, `legacy_irq_o[L]` is high.
- R4: Line numbers 0, 2, 8 and 13 are reserved. A pin mapped to one of them drives no output, so those four legacy outputs are always low.
- R5: When `pin_func_en_i[n]` is low, pin n has no effect on any output, whatever its mapping.
- R6: Configuration bits [14:12] pick the watchdog target:
  - 0, 1 and 2 give legacy lines 9, 10 and 11.
  - 3 drives nothing.
  - 4 to 7 give `adv_irq_o[0]` to `adv_irq_o[3]` (lines 20 to 23).
- R7: The watchdog route is live only while configuration bit 15 is 1 and `sci_route_i` is 0. Otherwise the watchdog drives no output.
- R8: The watchdog source is `wdog_sts_i`, ORed with `intr_sts_i` when `intr_to_irq_i` is 1. With `intr_to_irq_i` at 0, intrusion has no effect.
- R9: A routed watchdog source is a level. The target line stays high for every cycle that the synchronised source is high.
- R10: Several sources mapped to the same line are ORed. The line falls only when all of them are low.
- R11: A change on a pin or status input reaches the outputs after `SYNC_STAGES` (default 2) rising clock edges, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Current configuration |
| ext_pin_i | input | 3 | External interrupt pins, active high, asynchronous |
| pin_func_en_i | input | 3 | Per-pin interrupt-function enable |
| wdog_sts_i | input | 1 | Watchdog status, asynchronous |
| intr_sts_i | input | 1 | Intrusion status, asynchronous |
| intr_to_irq_i | input | 1 | 1 = intrusion joins the watchdog interrupt source |
| sci_route_i | input | 1 | 1 = system-control-interrupt routing active, watchdog route off |
| legacy_irq_o | output | 16 | Legacy interrupt request lines 0 to 15 |
| adv_irq_o | output | 4 | Advanced-controller lines 20 to 23 |

## Verification
A corrupted field in the configuration register appears in two places. It appears at once on `cfg_rdata` in the cycle after the write. It also appears as a lit output on the wrong line, one cycle after the write, provided a source is already high. A stuck or skipped synchroniser stage moves output changes one edge early or late relative to `SYNC_STAGES`. The bench samples each edge around the transition, so it catches either shift. A broken reserved-number or enable gate shows as a stray high line as soon as the synchronised pin rises.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int unsigned LEGACY_LINES = 16;
  localparam int unsigned ADV_LINES    = 4;
  localparam int unsigned EXT_PINS     = 3;
  localparam int unsigned WD_SEL_W     = 3;
  localparam int unsigned WD_BASE_IRQ  = 9;

  typedef enum logic [WD_SEL_W-1:0] {
    WD_TO_IRQ9  = 3'd0,
    WD_TO_IRQ10 = 3'd1,
    WD_TO_IRQ11 = 3'd2,
    WD_TO_NONE  = 3'd3,
    WD_TO_ADV0  = 3'd4,
    WD_TO_ADV1  = 3'd5,
    WD_TO_ADV2  = 3'd6,
    WD_TO_ADV3  = 3'd7
  } wd_target_e;

  function automatic logic line_reserved(input logic [3:0] num);
    return (num == 4'd0) || (num == 4'd2) || (num == 4'd8) || (num == 4'd13);
  endfunction

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_in_sync.sv
module irq_in_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_pin_decode.sv
module irq_pin_decode
  import irq_route_pkg::*;
#(
  parameter int unsigned LINES = LEGACY_LINES,
  localparam int unsigned SEL_W = $clog2(LINES)
) (
  input  logic             pin_i,
  input  logic             func_en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [LINES-1:0] lines_o
);
  logic route_ok;

  always_comb begin
    route_ok = func_en_i && !line_reserved(4'(sel_i));
    lines_o  = '0;
    if (route_ok && pin_i) lines_o[sel_i] = 1'b1;
  end
endmodule

// File: rtl/irq_wdog_route.sv
module irq_wdog_route
  import irq_route_pkg::*;
#(
  parameter int unsigned LINES = LEGACY_LINES,
  parameter int unsigned ADV_N = ADV_LINES
) (
  input  logic                wdog_i,
  input  logic                intr_i,
  input  logic                intr_to_irq_i,
  input  logic                sci_route_i,
  input  logic                en_i,
  input  logic [WD_SEL_W-1:0] sel_i,
  output logic [LINES-1:0]    legacy_o,
  output logic [ADV_N-1:0]    adv_o
);
  logic       src;
  logic       live;
  wd_target_e tgt;

  always_comb begin
    src      = wdog_i | (intr_i & intr_to_irq_i);
    live     = en_i & ~sci_route_i & src;
    tgt      = wd_target_e'(sel_i);
    legacy_o = '0;
    adv_o    = '0;
    if (live) begin
      unique case (tgt)
        WD_TO_IRQ9:  legacy_o[WD_BASE_IRQ]     = 1'b1;
        WD_TO_IRQ10: legacy_o[WD_BASE_IRQ + 1] = 1'b1;
        WD_TO_IRQ11: legacy_o[WD_BASE_IRQ + 2] = 1'b1;
        WD_TO_NONE:  ;
        WD_TO_ADV0:  adv_o[0] = 1'b1;
        WD_TO_ADV1:  adv_o[1] = 1'b1;
        WD_TO_ADV2:  adv_o[2] = 1'b1;
        WD_TO_ADV3:  adv_o[3] = 1'b1;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_PINS    = EXT_PINS,
  parameter int unsigned LEGACY_N    = LEGACY_LINES,
  parameter int unsigned ADV_N       = ADV_LINES,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SEL_W  = $clog2(LEGACY_N),
  localparam int unsigned WD_LSB = NUM_PINS * SEL_W,
  localparam int unsigned WD_EN  = WD_LSB + WD_SEL_W,
  localparam int unsigned CFG_W  = WD_EN + 1,
  localparam int unsigned IN_W   = NUM_PINS + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic [CFG_W-1:0]    cfg_rdata,
  input  logic [NUM_PINS-1:0] ext_pin_i,
  input  logic [NUM_PINS-1:0] pin_func_en_i,
  input  logic                wdog_sts_i,
  input  logic                intr_sts_i,
  input  logic                intr_to_irq_i,
  input  logic                sci_route_i,
  output logic [LEGACY_N-1:0] legacy_irq_o,
  output logic [ADV_N-1:0]    adv_irq_o
);
  logic                rst_q_n;
  logic [CFG_W-1:0]    cfg_q;
  logic [CFG_W-1:0]    cfg_d;
  logic [IN_W-1:0]     raw_in;
  logic [IN_W-1:0]     syn_in;
  logic [NUM_PINS-1:0] pin_s;
  logic                wdog_s;
  logic                intr_s;
  logic [NUM_PINS-1:0][LEGACY_N-1:0] pin_lines;
  logic [LEGACY_N-1:0] wd_legacy;
  logic [ADV_N-1:0]    wd_adv;

  irq_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk(clk), .rst_async_n(rst_n), .rst_sync_n(rst_q_n)
  );

  assign raw_in = {intr_sts_i, wdog_sts_i, ext_pin_i};

  irq_in_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) in_sync_i (
    .clk(clk), .rst_n(rst_q_n), .d_i(raw_in), .q_o(syn_in)
  );

  assign pin_s  = syn_in[NUM_PINS-1:0];
  assign wdog_s = syn_in[NUM_PINS];
  assign intr_s = syn_in[NUM_PINS+1];

  always_comb cfg_d = cfg_wdata;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  assign cfg_rdata = cfg_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    irq_pin_decode #(.LINES(LEGACY_N)) dec_i (
      .pin_i    (pin_s[p]),
      .func_en_i(pin_func_en_i[p]),
      .sel_i    (cfg_q[p*SEL_W +: SEL_W]),
      .lines_o  (pin_lines[p])
    );
  end

  irq_wdog_route #(.LINES(LEGACY_N), .ADV_N(ADV_N)) wd_i (
    .wdog_i       (wdog_s),
    .intr_i       (intr_s),
    .intr_to_irq_i(intr_to_irq_i),
    .sci_route_i  (sci_route_i),
    .en_i         (cfg_q[WD_EN]),
    .sel_i        (cfg_q[WD_LSB +: WD_SEL_W]),
    .legacy_o     (wd_legacy),
    .adv_o        (wd_adv)
  );

  always_comb begin
    legacy_irq_o = wd_legacy;
    for (int p = 0; p < NUM_PINS; p++) legacy_irq_o |= pin_lines[p];
    adv_irq_o = wd_adv;
  end
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int unsigned CFG_W    = 16,
  parameter int unsigned LEGACY_N = 16,
  parameter int unsigned ADV_N    = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_we,
  input logic [CFG_W-1:0]    cfg_wdata,
  input logic [CFG_W-1:0]    cfg_rdata,
  input logic                sci_route_i,
  input logic [LEGACY_N-1:0] legacy_irq_o,
  input logic [ADV_N-1:0]    adv_irq_o
);
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata));

  a_r4_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(legacy_irq_o[0] | legacy_irq_o[2] | legacy_irq_o[8] | legacy_irq_o[13]));

  a_r6_adv_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(adv_irq_o));

  a_r7_sci_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    sci_route_i |-> adv_irq_o == '0);

  a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[CFG_W-1] |-> adv_irq_o == '0);
endmodule

bind irq_route_matrix irq_route_chk #(
  .CFG_W(CFG_W), .LEGACY_N(LEGACY_N), .ADV_N(ADV_N)
) chk_i (
  .clk(clk), .rst_n(rst_q_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .sci_route_i(sci_route_i),
  .legacy_irq_o(legacy_irq_o), .adv_irq_o(adv_irq_o)
);

// File: tb/irq_route_matrix_tb_top.sv
`timescale 1ns/1ps
module irq_route_matrix_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic [2:0]  ext_pin_i;
  logic [2:0]  pin_func_en_i;
  logic        wdog_sts_i, intr_sts_i, intr_to_irq_i, sci_route_i;
  logic [15:0] legacy_irq_o;
  logic [3:0]  adv_irq_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_route_matrix dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ext_pin_i(ext_pin_i), .pin_func_en_i(pin_func_en_i),
    .wdog_sts_i(wdog_sts_i), .intr_sts_i(intr_sts_i), .intr_to_irq_i(intr_to_irq_i),
    .sci_route_i(sci_route_i), .legacy_irq_o(legacy_irq_o), .adv_irq_o(adv_irq_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Expected outputs derived from the requirements: {adv[3:0], legacy[15:0]}
  function automatic logic [19:0] model(input logic [15:0] cfg, input logic [2:0] pins,
                                        input logic [2:0] en, input logic wd, input logic it,
                                        input logic i2q, input logic sci);
    logic [15:0] lg = '0;
    logic [3:0]  av = '0;
    logic        src;
    for (int p = 0; p < 3; p++) begin
      int l = int'(cfg[p*4 +: 4]);
      if (pins[p] && en[p] && l != 0 && l != 2 && l != 8 && l != 13) lg[l] = 1'b1;
    end
    src = wd | (it & i2q);
    if (cfg[15] && !sci && src) begin
      int s = int'(cfg[14:12]);
      if (s < 3)      lg[9 + s] = 1'b1;
      else if (s > 3) av[s - 4] = 1'b1;
    end
    return {av, lg};
  endfunction

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string req);
    check(req, {12'd0, adv_irq_o, legacy_irq_o},
          {12'd0, model(cfg_rdata, ext_pin_i, pin_func_en_i, wdog_sts_i, intr_sts_i,
                        intr_to_irq_i, sci_route_i)});
  endtask

  task automatic t_reset();
    #1;
    check("R1 cfg", {16'd0, cfg_rdata}, 32'h0);
    check("R1 legacy", {16'd0, legacy_irq_o}, 32'h0);
    check("R1 adv", {28'd0, adv_irq_o}, 32'h0);
  endtask

  task automatic t_readback();
    write_cfg(16'hA5C3);
    check("R2 readback", {16'd0, cfg_rdata}, 32'hA5C3);
    repeat (3) @(negedge clk);
    check("R2 hold", {16'd0, cfg_rdata}, 32'hA5C3);
    write_cfg(16'h0000);
  endtask

  task automatic t_pin_map();
    pin_func_en_i = 3'b111;
    write_cfg(16'h0C75);
    ext_pin_i = 3'b001; settle();
    check("R3 pin0->5", {16'd0, legacy_irq_o}, 32'h0020);
    ext_pin_i = 3'b010; settle();
    check("R3 pin1->7", {16'd0, legacy_irq_o}, 32'h0080);
    ext_pin_i = 3'b100; settle();
    check("R3 pin2->12", {16'd0, legacy_irq_o}, 32'h1000);
    ext_pin_i = 3'b111; settle();
    expect_out("R3 all pins");
    ext_pin_i = 3'b000; settle();
  endtask

  task automatic t_reserved();
    pin_func_en_i = 3'b111;
    write_cfg(16'h0D82);
    ext_pin_i = 3'b111; settle();
    check("R4 reserved 2/8/13", {16'd0, legacy_irq_o}, 32'h0);
    write_cfg(16'h0300);
    check("R4 reserved 0 with pin2->3", {16'd0, legacy_irq_o}, 32'h0008);
    ext_pin_i = 3'b000; settle();
  endtask

  task automatic t_func_en();
    write_cfg(16'h0C75);
    pin_func_en_i = 3'b000;
    ext_pin_i = 3'b111; settle();
    check("R5 all disabled", {16'd0, legacy_irq_o}, 32'h0);
    pin_func_en_i = 3'b010; #1;
    check("R5 only pin1", {16'd0, legacy_irq_o}, 32'h0080);
    ext_pin_i = 3'b000; pin_func_en_i = 3'b111; settle();
  endtask

  task automatic t_wdog_sel();
    wdog_sts_i = 1'b1; settle();
    for (int s = 0; s < 8; s++) begin
      write_cfg(16'h8000 | 16'(s << 12));
      expect_out($sformatf("R6 sel %0d", s));
    end
    write_cfg(16'hC000);
    check("R6 sel4 adv0", {28'd0, adv_irq_o}, 32'h1);
    write_cfg(16'h3000);
    check("R7 enable off", {12'd0, adv_irq_o, legacy_irq_o}, 32'h0);
    write_cfg(16'h9000);
    sci_route_i = 1'b1; #1;
    check("R7 sci blocks", {12'd0, adv_irq_o, legacy_irq_o}, 32'h0);
    sci_route_i = 1'b0; #1;
    check("R7 sci clear", {16'd0, legacy_irq_o}, 32'h0400);
    wdog_sts_i = 1'b0; settle();
  endtask

  task automatic t_intrusion();
    write_cfg(16'h8000);
    intr_sts_i = 1'b1; intr_to_irq_i = 1'b0; settle();
    check("R8 intrusion unselected", {16'd0, legacy_irq_o}, 32'h0);
    intr_to_irq_i = 1'b1; #1;
    check("R8 intrusion selected", {16'd0, legacy_irq_o}, 32'h0200);
    intr_sts_i = 1'b0; intr_to_irq_i = 1'b0; settle();
  endtask

  task automatic t_level();
    int bad = 0;
    write_cfg(16'hA000);
    wdog_sts_i = 1'b1; settle();
    for (int c = 0; c < 10; c++) begin
      if (legacy_irq_o !== 16'h0800) bad++;
      @(negedge clk);
    end
    check("R9 level held 10 cycles", bad, 0);
    wdog_sts_i = 1'b0; settle();
    check("R9 level released", {16'd0, legacy_irq_o}, 32'h0);
  endtask

  task automatic t_or();
    pin_func_en_i = 3'b111;
    write_cfg(16'h900A);
    ext_pin_i = 3'b001; wdog_sts_i = 1'b1; settle();
    check("R10 both", {16'd0, legacy_irq_o}, 32'h0400);
    ext_pin_i = 3'b000; settle();
    check("R10 wdog only", {16'd0, legacy_irq_o}, 32'h0400);
    ext_pin_i = 3'b001; wdog_sts_i = 1'b0; settle();
    check("R10 pin only", {16'd0, legacy_irq_o}, 32'h0400);
    ext_pin_i = 3'b000; settle();
    check("R10 none", {16'd0, legacy_irq_o}, 32'h0);
  endtask

  task automatic t_latency();
    write_cfg(16'h0006);
    @(negedge clk); ext_pin_i = 3'b001;
    @(posedge clk); #1;
    check("R11 not after 1 edge", {16'd0, legacy_irq_o}, 32'h0);
    @(posedge clk); #1;
    check("R11 after 2 edges", {16'd0, legacy_irq_o}, 32'h0040);
    @(negedge clk); ext_pin_i = 3'b000;
    @(posedge clk); #1;
    check("R11 fall not after 1 edge", {16'd0, legacy_irq_o}, 32'h0040);
    @(posedge clk); #1;
    check("R11 fall after 2 edges", {16'd0, legacy_irq_o}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; ext_pin_i = '0; pin_func_en_i = '0;
    wdog_sts_i = 1'b0; intr_sts_i = 1'b0; intr_to_irq_i = 1'b0; sci_route_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_readback();
    t_pin_map();
    t_reserved();
    t_func_en();
    t_wdog_sel();
    t_intrusion();
    t_level();
    t_or();
    t_latency();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule